// File: doc/BRIEF.md
# Cascaded Dual-Processor Interrupt Controller

This block gathers 96 level-sensitive interrupt sources and drives one interrupt request line to each of two processors. Sixty-four main sources sit in two 32-bit cause words: a low word for numbers 0–31 and a high word for numbers 32–63. Thirty-two general-purpose pin inputs are held in a separate sticky cause word. They are numbered 64–95 and reach the high word through four summary bits, one for each group of eight pins.

The first processor has a mask for each main word, and the pins share one pin mask. A read port returns the current mask and pin cause values. It also returns the number of the pending interrupt that wins arbitration, or an invalid code when nothing is pending. Software can rewrite a whole mask word through the write port. It can also enable or disable a single interrupt by number, which changes exactly one mask bit. The second processor takes part only in the doorbell source, and it has its own single-bit mask for it.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset these values read back as follows: low mask (address 0) is 0, high mask (address 1) is 0x0F000000, pin mask (address 2) is 0, pin cause (address 3) is 0, second-processor mask (address 4) is 0. Both request outputs are low.
- R2: Reading address 5 returns the winner. When an eligible low-word bit is both pending and enabled, the winner is the highest such bit index (0–31). Main cause bits follow their inputs with no storage.
- R3: Only bits set in 0x3DFFFFFE take part in the low word, and only bits set in 0x1F0003F7 take part in the high word. A pending and enabled bit outside these sets neither wins nor raises a request.
- R4: The high word is used only when the low word has no candidate. A winning high bit k outside 24–27 reports the number 32+k.
- R5: High-word bit 24+g is the OR of the pin cause bits 8g..8g+7 that are enabled by the pin mask. When the high-word winner falls in 24–27, the reported number is 64 plus the highest enabled pending pin.
- R6: When neither word has a candidate, the winner read returns 0xFFFFFFFE.
- R7: A pin cause bit is set on each clock edge while its pin input is high. It is held until software writes 0 to that bit at address 3. Writing 1 leaves the bit unchanged, and a clear has no effect while the pin is still high.
- R8: A single-source operation on the first processor (op_cpu1=0) sets the mask bit to op_set. Numbers 0–31 select low mask bit n, 32–63 select high mask bit n-32, and 64–95 select pin mask bit n-64. No other mask bit changes, and numbers 96–127 change nothing.
- R9: The second processor's request is registered from low source 28 ANDed with its own mask bit, which reads at bit 28 of address 4. A single-source operation with op_cpu1=1 affects only that bit, and only for number 28.
- R10: The first processor's request is registered one cycle after the inputs. It is high when any eligible bit of either word is pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| low_src | input | 32 | Level inputs, numbers 0–31 |
| high_lo_src | input | 24 | Level inputs, numbers 32–55 |
| high_up_src | input | 4 | Level inputs, numbers 60–63 |
| pin_src | input | 32 | General-purpose pin levels, numbers 64–95 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 low mask, 1 high mask, 2 pin mask, 3 pin cause, 4 doorbell mask) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address (0–4 as for writes, 5 winner) |
| rd_data | output | 32 | Read data, combinational |
| op_en | input | 1 | Single-source mask operation strobe |
| op_set | input | 1 | 1 enables the source, 0 disables it |
| op_cpu1 | input | 1 | Operation targets the second processor |
| op_num | input | 7 | Interrupt number for the operation |
| cpu0_irq | output | 1 | Registered request to the first processor |
| cpu1_irq | output | 1 | Registered request to the second processor |

## Verification
The pin-cause properties assume that no pin input is high while reset is held. They also compare against the previous cycle only once the cycle before was out of reset. The bench therefore holds every source low through reset. The single-bit mask property assumes that a whole-word write and a single-source operation never share a cycle. The bench only issues them in separate cycles.

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl #(
  parameter logic [31:0] LO_ELIG  = 32'h3DFF_FFFE,
  parameter logic [31:0] HI_ELIG  = 32'h1F00_03F7,
  parameter logic [31:0] MHI_INIT = 32'h0F00_0000,
  parameter logic [31:0] NO_WIN   = 32'hFFFF_FFFE,
  parameter int          DB_BIT   = 28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] low_src,
  input  logic [23:0] high_lo_src,
  input  logic [3:0]  high_up_src,
  input  logic [31:0] pin_src,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        op_en,
  input  logic        op_set,
  input  logic        op_cpu1,
  input  logic [6:0]  op_num,
  output logic        cpu0_irq,
  output logic        cpu1_irq
);
  localparam int GRP = 8;

  logic [31:0] mask_lo, mask_hi, pin_mask, pin_cause;
  logic        db_mask;
  logic [31:0] nxt_lo, nxt_hi, nxt_pm;
  logic        nxt_db;
  logic [31:0] pin_act, cause_hi, act_lo, act_hi, winner;
  logic [3:0]  summ;
  logic [5:0]  w_lo, w_hi, w_pin;

  function automatic logic [5:0] top_bit(input logic [31:0] v);
    top_bit = '0;
    for (int i = 0; i < 32; i++)
      if (v[i]) top_bit = {1'b1, 5'(i)};
  endfunction

  assign pin_act = pin_cause & pin_mask;

  for (genvar g = 0; g < 4; g++) begin : g_summ
    assign summ[g] = |pin_act[g*GRP +: GRP];
  end

  assign cause_hi = {high_up_src, summ, high_lo_src};
  assign act_lo   = low_src & mask_lo & LO_ELIG;
  assign act_hi   = cause_hi & mask_hi & HI_ELIG;
  assign w_lo     = top_bit(act_lo);
  assign w_hi     = top_bit(act_hi);
  assign w_pin    = top_bit(pin_act);

  always_comb begin
    winner = NO_WIN;
    if (w_lo[5])
      winner = {27'd0, w_lo[4:0]};
    else if (w_hi[5]) begin
      if (w_hi[4:3] == 2'b11 && w_hi[2] == 1'b0)
        winner = 32'd64 + {27'd0, w_pin[4:0]};
      else
        winner = 32'd32 + {27'd0, w_hi[4:0]};
    end
  end

  always_comb begin
    nxt_lo = mask_lo;
    nxt_hi = mask_hi;
    nxt_pm = pin_mask;
    nxt_db = db_mask;
    if (wr_en) begin
      case (wr_addr)
        3'd0: nxt_lo = wr_data;
        3'd1: nxt_hi = wr_data;
        3'd2: nxt_pm = wr_data;
        3'd4: nxt_db = wr_data[DB_BIT];
        default: ;
      endcase
    end
    if (op_en) begin
      if (op_cpu1) begin
        if (op_num == 7'(DB_BIT)) nxt_db = op_set;
      end else begin
        case (op_num[6:5])
          2'b00: nxt_lo[op_num[4:0]] = op_set;
          2'b01: nxt_hi[op_num[4:0]] = op_set;
          2'b10: nxt_pm[op_num[4:0]] = op_set;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_lo   <= '0;
      mask_hi   <= MHI_INIT;
      pin_mask  <= '0;
      db_mask   <= 1'b0;
      pin_cause <= '0;
      cpu0_irq  <= 1'b0;
      cpu1_irq  <= 1'b0;
    end else begin
      mask_lo   <= nxt_lo;
      mask_hi   <= nxt_hi;
      pin_mask  <= nxt_pm;
      db_mask   <= nxt_db;
      pin_cause <= ((wr_en && wr_addr == 3'd3) ? (pin_cause & wr_data) : pin_cause) | pin_src;
      cpu0_irq  <= |act_lo | |act_hi;
      cpu1_irq  <= low_src[DB_BIT] & db_mask;
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = mask_lo;
      3'd1:    rd_data = mask_hi;
      3'd2:    rd_data = pin_mask;
      3'd3:    rd_data = pin_cause;
      3'd4:    rd_data = 32'(db_mask) << DB_BIT;
      3'd5:    rd_data = winner;
      default: rd_data = '0;
    endcase
  end
endmodule

module irq_cascade_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] low_src,
  input logic [31:0] pin_src,
  input logic        wr_en,
  input logic        op_en,
  input logic        op_cpu1,
  input logic [6:0]  op_num,
  input logic [2:0]  rd_addr,
  input logic [31:0] rd_data,
  input logic        cpu1_irq,
  input logic [31:0] mask_lo,
  input logic [31:0] pin_cause
);
  p_doorbell_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu1_irq |-> $past(low_src[28]));

  p_pin_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pin_cause & $past(pin_src)) == $past(pin_src)));

  p_pin_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pin_cause & ~$past(pin_cause) & ~$past(pin_src)) == 32'd0));

  p_win_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd5) |-> (rd_data == 32'hFFFF_FFFE || rd_data < 32'd96));

  p_single_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_en && !op_cpu1 && !wr_en && op_num < 7'd32))
      |-> ($countones(mask_lo ^ $past(mask_lo)) <= 1));
endmodule

bind irq_cascade_ctrl irq_cascade_chk u_chk (
  .clk(clk), .rst_n(rst_n), .low_src(low_src), .pin_src(pin_src),
  .wr_en(wr_en), .op_en(op_en), .op_cpu1(op_cpu1), .op_num(op_num),
  .rd_addr(rd_addr), .rd_data(rd_data), .cpu1_irq(cpu1_irq),
  .mask_lo(mask_lo), .pin_cause(pin_cause)
);

// File: tb/test_irq_cascade_ctrl.sv
`timescale 1ns/1ps
module test_irq_cascade_ctrl;
  localparam logic [31:0] LOE = 32'h3DFF_FFFE;
  localparam logic [31:0] HIE = 32'h1F00_03F7;
  localparam logic [31:0] NONE = 32'hFFFF_FFFE;

  logic clk = 0, rst_n = 0;
  logic [31:0] low_src = 0, pin_src = 0, wr_data = 0;
  logic [23:0] high_lo_src = 0;
  logic [3:0]  high_up_src = 0;
  logic wr_en = 0, op_en = 0, op_set = 0, op_cpu1 = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [6:0] op_num = 0;
  logic [31:0] rd_data;
  logic cpu0_irq, cpu1_irq;

  int checks = 0, fails = 0;
  logic [31:0] m_lo, m_hi, m_pm, m_pc;
  logic m_db;

  irq_cascade_ctrl i_irq_cascade_ctrl (
    .clk(clk), .rst_n(rst_n), .low_src(low_src), .high_lo_src(high_lo_src),
    .high_up_src(high_up_src), .pin_src(pin_src), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .op_en(op_en),
    .op_set(op_set), .op_cpu1(op_cpu1), .op_num(op_num), .cpu0_irq(cpu0_irq),
    .cpu1_irq(cpu1_irq));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick; wr_en = 0;
  endtask

  task automatic op(input logic s, input logic c1, input logic [6:0] n);
    op_en = 1; op_set = s; op_cpu1 = c1; op_num = n; tick; op_en = 0;
  endtask

  function automatic logic [31:0] hi_word();
    logic [31:0] pa;
    logic [3:0] sm;
    pa = m_pc & m_pm;
    for (int g = 0; g < 4; g++) sm[g] = |pa[g*8 +: 8];
    return {high_up_src, sm, high_lo_src};
  endfunction

  function automatic logic [31:0] exp_win();
    logic [31:0] al, ah, pa;
    al = low_src & m_lo & LOE;
    ah = hi_word() & m_hi & HIE;
    pa = m_pc & m_pm;
    for (int i = 31; i >= 0; i--) if (al[i]) return i;
    for (int i = 31; i >= 0; i--)
      if (ah[i]) begin
        if (i >= 24 && i <= 27)
          for (int p = 31; p >= 0; p--) if (pa[p]) return 64 + p;
        return 32 + i;
      end
    return NONE;
  endfunction

  function automatic logic exp_irq0();
    return |(low_src & m_lo & LOE) | |(hi_word() & m_hi & HIE);
  endfunction

  initial begin
    #(20ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, lf;
    repeat (3) tick;
    rst_n = 1;
    tick;
    m_lo = 0; m_hi = 32'h0F00_0000; m_pm = 0; m_pc = 0; m_db = 0;
    // R1 reset state
    rd(0, d); chk("R1 low mask", d, 0);
    rd(1, d); chk("R1 high mask", d, 32'h0F00_0000);
    rd(2, d); chk("R1 pin mask", d, 0);
    rd(3, d); chk("R1 pin cause", d, 0);
    rd(4, d); chk("R1 db mask", d, 0);
    chk("R1 irqs", {cpu0_irq, cpu1_irq}, 0);
    rd(5, d); chk("R6 idle winner", d, NONE);

    wr(0, '1); wr(1, '1); wr(2, '1);
    m_lo = '1; m_hi = '1; m_pm = '1;

    // R2 R3 R10 low word sweep
    for (int i = 0; i < 32; i++) begin
      low_src = 32'd1 << i;
      rd(5, d); chk("R2 R3 low winner", d, LOE[i] ? i : NONE);
      tick; chk("R10 R3 cpu0 irq low", cpu0_irq, LOE[i]);
    end
    low_src = 0;

    // R4 R3 high word sweep
    for (int j = 0; j < 32; j++) begin
      if (j >= 24 && j <= 27) continue;
      if (j < 24) begin high_lo_src = 24'd1 << j; high_up_src = 0; end
      else begin high_lo_src = 0; high_up_src = 4'd1 << (j - 28); end
      rd(5, d); chk("R4 R3 high winner", d, HIE[j] ? 32 + j : NONE);
      tick; chk("R10 cpu0 irq high", cpu0_irq, HIE[j]);
    end
    high_up_src = 0;

    // R4 low beats high
    high_lo_src = 24'd1 << 1; low_src = 32'd1 << 5;
    rd(5, d); chk("R4 low first", d, 5);
    low_src = 32'd1;
    rd(5, d); chk("R4 R3 ineligible low defers", d, 33);
    low_src = 0; high_lo_src = 0;

    // R5 R7 pin sweep
    for (int p = 0; p < 32; p++) begin
      pin_src = 32'd1 << p; tick; pin_src = 0; m_pc = 32'd1 << p;
      rd(3, d); chk("R7 pin cause set", d, 32'd1 << p);
      rd(5, d); chk("R5 pin winner", d, 64 + p);
      wr(3, '1);
      rd(3, d); chk("R7 write one keeps", d, 32'd1 << p);
      wr(3, ~(32'd1 << p)); m_pc = 0;
      rd(3, d); chk("R7 write zero clears", d, 0);
    end

    // R7 clear while level high
    pin_src = 32'h0000_0100; tick;
    wr(3, 0);
    rd(3, d); chk("R7 clear while high", d, 32'h0000_0100);
    pin_src = 0; wr(3, 0);
    rd(3, d); chk("R7 cleared after drop", d, 0);

    // R5 R8 summary gating
    pin_src = 32'h0000_0200; tick; pin_src = 0; m_pc = 32'h0000_0200;
    op(0, 0, 7'd57); m_hi[25] = 0;
    rd(1, d); chk("R8 high mask single bit", d, m_hi);
    rd(5, d); chk("R5 summary masked", d, NONE);
    op(1, 0, 7'd57); m_hi[25] = 1;
    rd(5, d); chk("R5 summary passes", d, 73);
    op(0, 0, 7'd73); m_pm[9] = 0;
    rd(5, d); chk("R5 pin masked", d, NONE);
    wr(3, 0); m_pc = 0;

    // R8 single-source ops over all numbers
    for (int n = 0; n < 96; n++) begin
      op(n[0], 0, 7'(n));
      if (n < 32) m_lo[n] = n[0];
      else if (n < 64) m_hi[n-32] = n[0];
      else m_pm[n-64] = n[0];
      rd(0, d); chk("R8 low mask", d, m_lo);
      rd(1, d); chk("R8 high mask", d, m_hi);
      rd(2, d); chk("R8 pin mask", d, m_pm);
    end
    for (int n = 96; n < 128; n++) op(1, 0, 7'(n));
    rd(0, d); chk("R8 out of range low", d, m_lo);
    rd(1, d); chk("R8 out of range high", d, m_hi);
    rd(2, d); chk("R8 out of range pin", d, m_pm);
    op(1, 1, 7'd5);
    rd(0, d); chk("R9 cpu1 op other number", d, m_lo);
    rd(4, d); chk("R9 cpu1 op other number db", d, 0);

    // R9 doorbell
    low_src = 32'h1000_0000; tick;
    chk("R9 db masked", cpu1_irq, 0);
    op(1, 1, 7'd28); m_db = 1;
    rd(4, d); chk("R9 db mask bit", d, 32'h1000_0000);
    tick; chk("R9 db request", cpu1_irq, 1);
    op(0, 0, 7'd28); m_lo[28] = 0;
    tick; chk("R9 independent of cpu0 mask", cpu1_irq, 1);
    low_src = 32'h0000_0020; tick;
    chk("R9 other source ignored", cpu1_irq, 0);
    low_src = 0;

    // Mixed patterns
    lf = 32'hACE1_1234;
    wr(0, 32'hF0F0_F0F0); m_lo = 32'hF0F0_F0F0;
    wr(1, 32'hFFFF_00FF); m_hi = 32'hFFFF_00FF;
    wr(2, 32'h5A5A_5A5A); m_pm = 32'h5A5A_5A5A;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      low_src = (k % 3 == 0) ? (lf & 32'h0000_0F01) : 0;
      high_lo_src = lf[23:0] & {24{k[1]}};
      high_up_src = lf[31:28];
      pin_src = {lf[15:0], lf[31:16]} & {32{k[0]}};
      tick; m_pc = m_pc | pin_src; pin_src = 0;
      rd(5, d); chk("R2 R4 R5 mixed winner", d, exp_win());
      tick; chk("R10 mixed cpu0 irq", cpu0_irq, exp_irq0());
      if (k % 4 == 3) begin wr(3, 0); m_pc = 0; end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule